// File: doc/BRIEF.md
# CEC Frame Transmit Retry Controller

This block runs the transmission of one CEC frame on behalf of a host. Through a byte-wide write port the host loads the frame into a small transmit buffer, writes the frame length and a retry limit, and then sets an enable bit. The controller starts an attempt on an attached bit-level line transmitter. It supplies the frame one byte at a time, starting with the header byte, and waits for the line result.

A NACK or a low-drive failure causes the controller to start the attempt again, up to the programmed number of retries. Losing arbitration ends the transaction at once. Every transaction ends with one of three sticky outcome flags: ready, arbitration lost or retry timeout. The enable bit clears itself when the transaction ends. Two saturating failure counters, one for NACKs and one for low-drive errors, are packed into one status word. Both restart at zero with each new transmission. Line timing and signal-free-time measurement belong to the attached transmitter.

Top module: `cec_tx_retry_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all outcome flags, the enable output, both failure counts and `xmt_start` are 0.
- R2: Host writes use these addresses: 0..DEPTH-1 for buffer bytes, DEPTH for length, DEPTH+1 for the retry limit, DEPTH+2 for enable, DEPTH+3 for flag clear. When a valid length is loaded and a 1 is written to enable bit 0, `xmt_start` is high for exactly one cycle, on the cycle after the write. During the attempt `xmt_byte` shows buffer entry k, starting at k=0. Each `xmt_byte_ack` moves k to the next entry. `xmt_last` is high while k equals length-1.
- R3: A line result of 0 (acknowledged) sets the ready flag and clears `tx_enable` on the same clock edge.
- R4: A line result of 3 (arbitration lost) sets the arbitration-lost flag, clears `tx_enable` and starts no further attempt.
- R5: A line result of 1 (NACK) or 2 (low drive) starts a new attempt, as long as the number of retries so far is below the retry limit. The retry limit is held in bits [6:4] of the retry-limit register. A limit of 0 is treated as 1. A transaction therefore makes at most limit+1 attempts.
- R6: A failure that occurs after the retries are used up sets the retry-timeout flag, clears `tx_enable` and starts nothing more.
- R7: `err_counts` holds the NACK count in bits [CNT_W-1:0] and the low-drive count in bits [2*CNT_W-1:CNT_W]. Each count goes up by one per matching failure and stops at its maximum. Both counts return to 0 whenever a transmission is started.
- R8: If enable is set while the length is 0 or greater than DEPTH, the retry-timeout flag is set at once, `tx_enable` stays 0 and `xmt_start` is never raised.
- R9: Writing 1s to the flag-clear register clears flags as follows: bit 0 clears ready, bit 1 clears arbitration lost, bit 2 clears timeout. If a flag is set and cleared on the same edge, it ends up set. At most one flag is set per cycle.
- R10: While a transaction is in progress, writes to the buffer, the length, the retry limit and the enable register have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host write address |
| host_wdata | input | 8 | Host write data |
| xmt_start | output | 1 | One-cycle request to begin a line attempt |
| xmt_byte | output | 8 | Frame byte currently offered |
| xmt_last | output | 1 | Offered byte is the final one of the frame |
| xmt_byte_ack | input | 1 | Transmitter took the offered byte |
| xmt_done | input | 1 | Attempt finished, result valid |
| xmt_result | input | 2 | 0 ack, 1 NACK, 2 low drive, 3 arbitration lost |
| tx_enable | output | 1 | Transaction in progress |
| irq_ready | output | 1 | Sticky success flag |
| irq_arb_lost | output | 1 | Sticky arbitration-lost flag |
| irq_retry_timeout | output | 1 | Sticky retry-exhausted or bad-length flag |
| err_counts | output | 2*CNT_W | Packed low-drive and NACK counts |

## Verification
The bench builds the block with DEPTH 16 and the default 3-bit retry limit, but with CNT_W set to 2. Each counter therefore saturates at 3. A transaction of eight failed attempts at the top limit can then drive both counters into saturation. With 4-bit counters this cannot happen, because at most eight attempts are ever made. With the default DEPTH the length register can take values both just below and just above the buffer size, so the bad-length path is exercised on both sides.

// File: rtl/cec_tx_pkg.sv
// Shared types for the CEC transmit retry controller.
// Assumes: the attached line transmitter reports one 2-bit result per attempt.
package cec_tx_pkg;
    typedef enum logic [1:0] {
        RES_ACK     = 2'd0,
        RES_NACK    = 2'd1,
        RES_LOWDRV  = 2'd2,
        RES_ARBLOST = 2'd3
    } line_res_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_SEND   = 2'd2
    } sq_state_e;
endpackage

// File: rtl/cec_tx_frame_buf.sv
// Frame storage and host-written configuration (length, retry limit).
// Assumes: DEPTH is a power of two; every write is blocked while busy is high.
module cec_tx_frame_buf #(
    parameter int DEPTH   = 16,
    parameter int LIMIT_W = 3,
    parameter int ADDR_W  = 5,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic               busy,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [7:0]         rd_byte,
    output logic [7:0]         frame_len,
    output logic [LIMIT_W-1:0] retry_lim
);
    localparam logic [ADDR_W-1:0] LEN_ADDR = ADDR_W'(DEPTH);
    localparam logic [ADDR_W-1:0] LIM_ADDR = ADDR_W'(DEPTH + 1);

    logic       wr_ok;
    logic [7:0] mem [DEPTH];

    assign wr_ok = we && !busy;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        // Hold one frame byte; loaded by an idle-time host write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[e] <= '0;
            else if (wr_ok && addr == ADDR_W'(e))
                mem[e] <= wdata;
        end
    end

    // Hold the frame length and retry limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_len <= '0;
            retry_lim <= '0;
        end else if (wr_ok) begin
            if (addr == LEN_ADDR) frame_len <= wdata;
            if (addr == LIM_ADDR) retry_lim <= wdata[4 +: LIMIT_W];
        end
    end

    assign rd_byte = mem[rd_idx];

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && we) |=> ($stable(frame_len) && $stable(retry_lim)));
endmodule

// File: rtl/cec_tx_sat_ctr.sv
// Saturating failure counter: clears on a new transmission, stops at all ones.
// Assumes: clr and inc are never meaningful in the same cycle; clr wins.
module cec_tx_sat_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // Count failures, holding at the maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc && cnt != '1)
            cnt <= cnt + W'(1);
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == '1) |=> (cnt == '1));
endmodule

// File: rtl/cec_tx_seq.sv
// Attempt sequencer: launches line attempts, walks the frame bytes, decides
// between retry and termination, and raises one outcome strobe per transaction.
// Assumes: go is only asserted while idle; frame_len and retry_lim are frozen while busy.
module cec_tx_seq
    import cec_tx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LIMIT_W = 3,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [7:0]         frame_len,
    input  logic [LIMIT_W-1:0] retry_lim,
    input  logic               xmt_byte_ack,
    input  logic               xmt_done,
    input  line_res_e          xmt_result,
    output logic               busy,
    output logic               xmt_start,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               xmt_last,
    output logic               fail_nack,
    output logic               fail_low,
    output logic               set_ready,
    output logic               set_arb,
    output logic               set_timeout
);
    sq_state_e          state;
    logic [LIMIT_W-1:0] retries_done;
    logic [LIMIT_W-1:0] eff_lim;
    logic               len_ok;
    logic               send_done;
    logic               fail;
    logic               exhausted;

    assign len_ok    = (frame_len != 8'd0) && (frame_len <= 8'(DEPTH));
    assign eff_lim   = (retry_lim == '0) ? LIMIT_W'(1) : retry_lim;
    assign send_done = (state == SQ_SEND) && xmt_done;
    assign fail_nack = send_done && (xmt_result == RES_NACK);
    assign fail_low  = send_done && (xmt_result == RES_LOWDRV);
    assign fail      = fail_nack || fail_low;
    assign exhausted = (retries_done >= eff_lim);

    assign set_ready   = send_done && (xmt_result == RES_ACK);
    assign set_arb     = send_done && (xmt_result == RES_ARBLOST);
    assign set_timeout = (go && !len_ok) || (fail && exhausted);

    assign busy      = (state != SQ_IDLE);
    assign xmt_start = (state == SQ_LAUNCH);
    assign xmt_last  = ((8'(rd_idx) + 8'd1) == frame_len);

    // Advance the transaction state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE:   if (go && len_ok) state <= SQ_LAUNCH;
                SQ_LAUNCH: state <= SQ_SEND;
                SQ_SEND:   if (send_done) state <= (fail && !exhausted) ? SQ_LAUNCH : SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    // Count retries taken within the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            retries_done <= '0;
        else if (go)
            retries_done <= '0;
        else if (fail && !exhausted)
            retries_done <= retries_done + LIMIT_W'(1);
    end

    // Track which frame byte is offered to the line transmitter.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_idx <= '0;
        else if (state == SQ_LAUNCH)
            rd_idx <= '0;
        else if (state == SQ_SEND && !xmt_done && xmt_byte_ack && !xmt_last)
            rd_idx <= rd_idx + IDX_W'(1);
    end

    // R2
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xmt_start |=> !xmt_start);

    // R2
    idx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SEND) |-> (8'(rd_idx) < frame_len));

    // R4
    arb_no_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (send_done && xmt_result == RES_ARBLOST) |=> !busy);

    // R5
    retry_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !exhausted) |=> xmt_start);

    // R8
    bad_len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !len_ok) |=> !busy);
endmodule

// File: rtl/cec_tx_retry_ctrl.sv
// Top level of the CEC transmit retry controller: host write decode, sticky
// outcome flags, packed failure counters, frame buffer and attempt sequencer.
// Assumes: a single host writer; the line transmitter follows the start/ack/done protocol.
module cec_tx_retry_ctrl
    import cec_tx_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LIMIT_W = 3,
    parameter int CNT_W   = 4,
    localparam int ADDR_W = $clog2(DEPTH + 4)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [7:0]           host_wdata,
    output logic                 xmt_start,
    output logic [7:0]           xmt_byte,
    output logic                 xmt_last,
    input  logic                 xmt_byte_ack,
    input  logic                 xmt_done,
    input  logic [1:0]           xmt_result,
    output logic                 tx_enable,
    output logic                 irq_ready,
    output logic                 irq_arb_lost,
    output logic                 irq_retry_timeout,
    output logic [2*CNT_W-1:0]   err_counts
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] EN_ADDR  = ADDR_W'(DEPTH + 2);
    localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(DEPTH + 3);

    logic               busy;
    logic               go;
    logic [IDX_W-1:0]   rd_idx;
    logic [7:0]         frame_len;
    logic [LIMIT_W-1:0] retry_lim;
    logic               fail_nack;
    logic               fail_low;
    logic               set_ready;
    logic               set_arb;
    logic               set_timeout;
    logic [2:0]         clr_mask;
    logic [2:0]         flags;

    assign go        = host_we && (host_addr == EN_ADDR) && host_wdata[0] && !busy;
    assign clr_mask  = (host_we && host_addr == CLR_ADDR) ? host_wdata[2:0] : 3'b000;
    assign tx_enable = busy;

    cec_tx_frame_buf #(.DEPTH(DEPTH), .LIMIT_W(LIMIT_W), .ADDR_W(ADDR_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (host_we),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .busy      (busy),
        .rd_idx    (rd_idx),
        .rd_byte   (xmt_byte),
        .frame_len (frame_len),
        .retry_lim (retry_lim)
    );

    cec_tx_seq #(.DEPTH(DEPTH), .LIMIT_W(LIMIT_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (go),
        .frame_len    (frame_len),
        .retry_lim    (retry_lim),
        .xmt_byte_ack (xmt_byte_ack),
        .xmt_done     (xmt_done),
        .xmt_result   (line_res_e'(xmt_result)),
        .busy         (busy),
        .xmt_start    (xmt_start),
        .rd_idx       (rd_idx),
        .xmt_last     (xmt_last),
        .fail_nack    (fail_nack),
        .fail_low     (fail_low),
        .set_ready    (set_ready),
        .set_arb      (set_arb),
        .set_timeout  (set_timeout)
    );

    for (genvar k = 0; k < 2; k++) begin : g_ctr
        cec_tx_sat_ctr #(.W(CNT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (go),
            .inc   ((k == 0) ? fail_nack : fail_low),
            .cnt   (err_counts[k*CNT_W +: CNT_W])
        );
    end

    // Keep sticky outcome flags; a set on the same edge overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_mask) | {set_timeout, set_arb, set_ready};
    end

    assign irq_ready         = flags[0];
    assign irq_arb_lost      = flags[1];
    assign irq_retry_timeout = flags[2];

    // R3
    ready_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_ready) |-> !tx_enable);

    // R9
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_ready, set_arb, set_timeout}));

    // R9
    w1c_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == CLR_ADDR && host_wdata[0] && !set_ready) |=> !irq_ready);
endmodule

// File: tb/cec_tx_retry_ctrl_bench.sv
module cec_tx_retry_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int CNT_W = 2;
    localparam int CMAX  = 3;
    localparam int ADDR_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic xmt_byte_ack = 1'b0;
    logic xmt_done = 1'b0;
    logic [1:0] xmt_result = 2'd0;
    logic xmt_start, xmt_last, tx_enable, irq_ready, irq_arb_lost, irq_retry_timeout;
    logic [7:0] xmt_byte;
    logic [2*CNT_W-1:0] err_counts;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cec_tx_retry_ctrl #(.DEPTH(DEPTH), .LIMIT_W(3), .CNT_W(CNT_W)) u_cec_tx_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .xmt_start(xmt_start), .xmt_byte(xmt_byte),
        .xmt_last(xmt_last), .xmt_byte_ack(xmt_byte_ack), .xmt_done(xmt_done),
        .xmt_result(xmt_result), .tx_enable(tx_enable), .irq_ready(irq_ready),
        .irq_arb_lost(irq_arb_lost), .irq_retry_timeout(irq_retry_timeout),
        .err_counts(err_counts)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [DEPTH];
    int m_st, m_len, m_lim, m_idx, m_ret, m_nack, m_low;
    logic [2:0] m_fl, m_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_len = 0; m_lim = 0; m_idx = 0; m_ret = 0;
            m_nack = 0; m_low = 0; m_fl = 3'b000;
            foreach (m_mem[i]) m_mem[i] = 8'h00;
        end else begin
            m_set = 3'b000;
            if (host_we && host_addr == 5'd19) m_fl = m_fl & ~host_wdata[2:0];
            case (m_st)
                0: if (host_we) begin
                    if (host_addr < 5'd16) m_mem[host_addr[3:0]] = host_wdata;
                    else if (host_addr == 5'd16) m_len = int'(host_wdata);
                    else if (host_addr == 5'd17) m_lim = int'(host_wdata[6:4]);
                    else if (host_addr == 5'd18 && host_wdata[0]) begin
                        m_nack = 0; m_low = 0; m_ret = 0;
                        if (m_len == 0 || m_len > DEPTH) m_set[2] = 1'b1;
                        else m_st = 1;
                    end
                end
                1: begin m_st = 2; m_idx = 0; end
                default: if (xmt_done) begin
                    if (xmt_result == 2'd0) begin m_set[0] = 1'b1; m_st = 0; end
                    else if (xmt_result == 2'd3) begin m_set[1] = 1'b1; m_st = 0; end
                    else begin
                        if (xmt_result == 2'd1) m_nack = (m_nack < CMAX) ? m_nack + 1 : CMAX;
                        else m_low = (m_low < CMAX) ? m_low + 1 : CMAX;
                        if (m_ret >= ((m_lim == 0) ? 1 : m_lim)) begin m_set[2] = 1'b1; m_st = 0; end
                        else begin m_ret++; m_st = 1; end
                    end
                end else if (xmt_byte_ack && m_idx < m_len - 1) m_idx++;
            endcase
            m_fl = m_fl | m_set;
        end
    end

    // Compare the design against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(irq_ready == m_fl[0], "R3", irq_ready, m_fl[0]);
            chk(irq_arb_lost == m_fl[1], "R4", irq_arb_lost, m_fl[1]);
            chk(irq_retry_timeout == m_fl[2], "R6", irq_retry_timeout, m_fl[2]);
            chk(tx_enable == (m_st != 0), "R10", tx_enable, m_st != 0);
            chk(err_counts == {CNT_W'(m_low), CNT_W'(m_nack)}, "R7", err_counts, {CNT_W'(m_low), CNT_W'(m_nack)});
            chk(xmt_start == (m_st == 1), "R2", xmt_start, m_st == 1);
            if (m_st == 2) begin
                chk(xmt_byte == m_mem[m_idx], "R2", xmt_byte, m_mem[m_idx]);
                chk(xmt_last == (m_idx == m_len - 1), "R2", xmt_last, m_idx == m_len - 1);
            end
        end
    end

    // ---------------- stimulus tasks (start and end at a negedge) ----------------
    task automatic wr(input int a, input int d);
        host_we = 1'b1; host_addr = ADDR_W'(a); host_wdata = 8'(d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_start(output bit seen);
        seen = 1'b0;
        for (int w = 0; w < 12; w++) begin
            if (xmt_start) begin seen = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic attempt(input int res, input int nbytes, output bit seen);
        wait_start(seen);
        if (seen) begin
            @(negedge clk);
            for (int b = 0; b < nbytes - 1; b++) begin
                xmt_byte_ack = 1'b1; @(negedge clk); xmt_byte_ack = 1'b0;
            end
            xmt_done = 1'b1; xmt_result = 2'(res);
            @(negedge clk);
            xmt_done = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++; n_cmp++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit seen;
        int tries;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({irq_ready, irq_arb_lost, irq_retry_timeout, tx_enable, xmt_start} == 5'b0, "R1",
            {irq_ready, irq_arb_lost, irq_retry_timeout, tx_enable, xmt_start}, 0);
        chk(err_counts == 0, "R1", err_counts, 0);

        // R2/R3 successful three-byte frame
        wr(0, 8'h4F); wr(1, 8'h82); wr(2, 8'h10); wr(16, 3); wr(17, 8'h20); wr(18, 1);
        chk(xmt_start == 1'b1, "R2", xmt_start, 1);
        @(negedge clk);
        chk(xmt_start == 1'b0 && xmt_byte == 8'h4F && !xmt_last, "R2", xmt_byte, 8'h4F);
        xmt_byte_ack = 1'b1; @(negedge clk); xmt_byte_ack = 1'b0;
        chk(xmt_byte == 8'h82, "R2", xmt_byte, 8'h82);
        xmt_byte_ack = 1'b1; @(negedge clk); xmt_byte_ack = 1'b0;
        chk(xmt_byte == 8'h10 && xmt_last, "R2", {xmt_last, xmt_byte}, 9'h110);
        xmt_done = 1'b1; xmt_result = 2'd0; @(negedge clk); xmt_done = 1'b0;
        chk(irq_ready && !tx_enable, "R3", {irq_ready, tx_enable}, 2'b10);

        // R9 clear all flags
        wr(19, 7);
        chk({irq_ready, irq_arb_lost, irq_retry_timeout} == 3'b000, "R9",
            {irq_ready, irq_arb_lost, irq_retry_timeout}, 0);

        // R5/R6 limit 2: nack, low drive, nack -> timeout after 3 attempts
        wr(18, 1);
        tries = 0;
        attempt(1, 2, seen); tries += int'(seen);
        attempt(2, 3, seen); tries += int'(seen);
        attempt(1, 1, seen); tries += int'(seen);
        chk(tries == 3, "R5", tries, 3);
        chk(irq_retry_timeout && !tx_enable, "R6", {irq_retry_timeout, tx_enable}, 2'b10);
        chk(err_counts == 4'b0110, "R7", err_counts, 4'b0110);
        wait_start(seen);
        chk(!seen, "R6", seen, 0);

        // R4 arbitration lost ends at once
        wr(19, 7); wr(18, 1);
        attempt(3, 2, seen);
        chk(irq_arb_lost && !tx_enable && !irq_retry_timeout, "R4",
            {irq_arb_lost, tx_enable, irq_retry_timeout}, 3'b100);
        wait_start(seen);
        chk(!seen, "R4", seen, 0);

        // R5 limit 0 behaves as 1
        wr(19, 7); wr(17, 8'h00); wr(18, 1);
        tries = 0;
        attempt(1, 1, seen); tries += int'(seen);
        attempt(1, 1, seen); tries += int'(seen);
        wait_start(seen); tries += int'(seen);
        chk(tries == 2 && irq_retry_timeout, "R5", tries, 2);

        // R8 bad lengths
        wr(19, 7); wr(16, 0); wr(18, 1);
        chk(irq_retry_timeout && !tx_enable && !xmt_start, "R8", {irq_retry_timeout, tx_enable, xmt_start}, 3'b100);
        chk(err_counts == 0, "R7", err_counts, 0);
        wr(19, 7); wr(16, 17); wr(18, 1);
        chk(irq_retry_timeout && !tx_enable, "R8", {irq_retry_timeout, tx_enable}, 2'b10);
        wait_start(seen);
        chk(!seen, "R8", seen, 0);
        wr(16, 16); wr(19, 7); wr(18, 1);
        chk(xmt_start && !irq_retry_timeout, "R8", {xmt_start, irq_retry_timeout}, 2'b10);
        attempt(0, 16, seen);
        chk(irq_ready, "R3", irq_ready, 1);

        // R7 saturation: limit 7, eight NACKs
        wr(19, 7); wr(16, 3); wr(17, 8'h70); wr(18, 1);
        for (int a = 0; a < 8; a++) attempt(1, 1, seen);
        chk(err_counts == 4'b0011 && irq_retry_timeout, "R7", err_counts, 4'b0011);
        wr(19, 7); wr(18, 1);
        for (int a = 0; a < 4; a++) attempt(2, 2, seen);
        for (int a = 0; a < 4; a++) attempt(1, 1, seen);
        chk(err_counts == 4'b1111, "R7", err_counts, 4'b1111);

        // R10 writes while busy are ignored
        wr(19, 7); wr(17, 8'h10); wr(18, 1);
        wait_start(seen);
        @(negedge clk);
        wr(0, 8'hEE); wr(16, 5); wr(17, 8'h00); wr(18, 0);
        chk(tx_enable == 1'b1, "R10", tx_enable, 1);
        xmt_done = 1'b1; xmt_result = 2'd0; @(negedge clk); xmt_done = 1'b0;
        wr(18, 1);
        @(negedge clk);
        chk(xmt_byte == 8'h4F, "R10", xmt_byte, 8'h4F);
        xmt_byte_ack = 1'b1; @(negedge clk);
        @(negedge clk); xmt_byte_ack = 1'b0;
        chk(xmt_last, "R10", xmt_last, 1);

        // R9 set wins over a same-edge clear; other bits clear normally
        xmt_done = 1'b1; xmt_result = 2'd0;
        host_we = 1'b1; host_addr = 5'd19; host_wdata = 8'h07;
        @(negedge clk);
        xmt_done = 1'b0; host_we = 1'b0;
        chk(irq_ready && !irq_arb_lost && !irq_retry_timeout, "R9",
            {irq_ready, irq_arb_lost, irq_retry_timeout}, 3'b100);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule